// File: doc/BRIEF.md
# PHY Management Interface Master

This block gives software access to the registers of an Ethernet PHY over the two-wire management bus: a clock line (MDC) that the block drives, and a bidirectional data line (MDIO). Software programs a PHY address and a register number, then starts an access. A read begins when bit 0 of the command register changes from 0 to 1. A write begins as soon as a 16-bit value is stored into the write-data register. The block then sends one 64-bit frame and shows a busy flag until the frame ends. After a read, the value returned by the PHY can be fetched from the read-data register.

A config register sets the MDC rate and holds a management reset that stops any frame in progress. The indicator register shows the busy flag and a link-fail status taken from an input pin. All registers are 32 bits wide and are addressed by a 3-bit word index: 0 config, 1 command, 2 address, 3 write data, 4 read data, 5 indicator.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads as zero, MDC is low and the MDIO output enable is low.
- R2: The address register (word 2) keeps the PHY address in bits 12:8 and the register number in bits 4:0. All its other bits read as zero.
- R3: A write frame sends these bits, MSB first, one bit per MDC period: 32 ones, then 01, then opcode 01, then the 5-bit PHY address, then the 5-bit register number, then 10, then the 16 data bits. The line is driven for all 64 bits. The data output changes only after a falling edge of MDC, so it is stable when MDC rises.
- R4: A read frame sends opcode 10 and releases MDIO (output enable low) for its last 18 bit periods. It samples the PHY on the 16 final MDC rising edges. The sampled value then appears in bits 15:0 of the read-data register (word 4), with bits 31:16 reading as zero.
- R5: A read starts only when bit 0 of the command register (word 1) changes from 0 to 1. Writing 1 while the bit is already 1 starts nothing.
- R6: Indicator bit 0 (word 5) is set from the clock edge that accepts a command until the frame completes. A frame lasts 64 MDC periods, which is 64 × divisor system clocks.
- R7: Config bits 4:2 select the MDC divisor. Codes 0 to 7 give divisors 4, 4, 6, 8, 10, 20, 28 and 40, and MDC is high for half of each period.
- R8: While busy, no new frame starts, and writes to the address and write-data registers have no effect.
- R9: While config bit 15 is set, the sequencer is held idle: busy is cleared, MDC is low, the output enable is low, and commands are ignored.
- R10: Indicator bit 3 follows the link-fail input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| link_fail | input | 1 | Link-fail status shown in indicator bit 3 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
If the bit counter or the shift register goes wrong, the PHY model sees the wrong bits, or the wrong number of bits, on the very next MDC rising edge. It also changes how long busy stays set, which is checked to the exact system clock. If the divider decodes the wrong value, the measured MDC high and low times are off on the first period. If the turnaround timing is wrong, the output enable count is off, or the read-data register holds a value shifted by one bit. Both show up in the same frame.

// File: rtl/mdio_master.sv
module mdio_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        link_fail,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;
  localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_ADR = 3'd2,
                         A_WD  = 3'd3, A_RD  = 3'd4, A_IND = 3'd5;

  logic [2:0]  clk_sel;
  logic        mrst, cmd_bit, busy, is_wr;
  logic [4:0]  phy_ad, reg_ad, cnt, half;
  logic [15:0] wr_data, rd_data, rx;
  logic [5:0]  bitidx;
  logic [63:0] sh;

  always_comb
    case (clk_sel)
      3'd0, 3'd1: half = 5'd2;
      3'd2:       half = 5'd3;
      3'd3:       half = 5'd4;
      3'd4:       half = 5'd5;
      3'd5:       half = 5'd10;
      3'd6:       half = 5'd14;
      default:    half = 5'd20;
    endcase

  wire sel_cfg  = bus_wr && bus_addr == A_CFG;
  wire sel_cmd  = bus_wr && bus_addr == A_CMD;
  wire sel_adr  = bus_wr && bus_addr == A_ADR;
  wire sel_wd   = bus_wr && bus_addr == A_WD;
  wire start_rd = sel_cmd && bus_wdata[0] && !cmd_bit && !busy && !mrst;
  wire start_wr = sel_wd && !busy && !mrst;
  wire tick     = cnt >= half - 5'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sel <= '0; mrst <= 1'b0; cmd_bit <= 1'b0;
      phy_ad <= '0; reg_ad <= '0; wr_data <= '0; rd_data <= '0; rx <= '0;
      busy <= 1'b0; is_wr <= 1'b0; bitidx <= '0; cnt <= '0; mdc <= 1'b0; sh <= '0;
    end else begin
      if (sel_cfg) begin mrst <= bus_wdata[15]; clk_sel <= bus_wdata[4:2]; end
      if (sel_cmd) cmd_bit <= bus_wdata[0];
      if (sel_adr && !busy) begin phy_ad <= bus_wdata[12:8]; reg_ad <= bus_wdata[4:0]; end
      if (start_wr) wr_data <= bus_wdata[15:0];
      if (mrst) begin
        busy <= 1'b0; mdc <= 1'b0; cnt <= '0; bitidx <= '0;
      end else if (start_rd || start_wr) begin
        busy <= 1'b1; is_wr <= start_wr; bitidx <= '0; cnt <= '0; mdc <= 1'b0;
        sh <= {32'hFFFF_FFFF, 2'b01, start_wr ? 2'b01 : 2'b10, phy_ad, reg_ad,
               start_wr ? 2'b10 : 2'b11, start_wr ? bus_wdata[15:0] : 16'hFFFF};
      end else if (busy) begin
        if (tick) begin
          cnt <= '0;
          mdc <= !mdc;
          if (!mdc) begin
            if (!is_wr && bitidx >= 6'(DATA_BIT)) rx <= {rx[14:0], mdio_i};
          end else if (bitidx == 6'(FRAME_BITS - 1)) begin
            busy <= 1'b0;
            if (!is_wr) rd_data <= rx;
          end else begin
            bitidx <= bitidx + 6'd1;
            sh <= {sh[62:0], 1'b1};
          end
        end else cnt <= cnt + 5'd1;
      end
    end

  assign mdio_o  = busy && sh[63];
  assign mdio_oe = busy && (is_wr || bitidx < 6'(TA_BIT));

  always_comb
    case (bus_addr)
      A_CFG:   bus_rdata = {16'd0, mrst, 10'd0, clk_sel, 2'd0};
      A_CMD:   bus_rdata = {31'd0, cmd_bit};
      A_ADR:   bus_rdata = {19'd0, phy_ad, 3'd0, reg_ad};
      A_WD:    bus_rdata = {16'd0, wr_data};
      A_RD:    bus_rdata = {16'd0, rd_data};
      A_IND:   bus_rdata = {28'd0, link_fail, 2'd0, busy};
      default: bus_rdata = '0;
    endcase

  p_out_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(mdc)) |-> $stable(mdio_o));
  p_oe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  p_start_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bitidx == '0 && !mdc));
  p_mdc_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mdc);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mrst && $past(busy)) |-> ($stable(phy_ad) && $stable(reg_ad) && $stable(wr_data)));
  p_mrst_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (!busy && !mdc));
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, link_fail = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i, phy_drv = 1'b1;
  int checks = 0, fails = 0;
  int rtot = 0, base = 0;
  logic [15:0] phy_val = '0;
  logic cap [0:2047];
  logic oecap [0:2047];

  always #5 clk = !clk;

  mdio_master uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_fail(link_fail),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  always @(posedge mdc) begin
    cap[rtot % 2048] = mdio_i;
    oecap[rtot % 2048] = mdio_oe;
    rtot = rtot + 1;
  end

  always @(negedge mdc) begin
    int k;
    k = rtot - base;
    if (k == 47) phy_drv = 1'b0;
    else if (k >= 48 && k < 64) phy_drv = phy_val[63 - k];
    else phy_drv = 1'b1;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rd(3'd5, v);
    while (v[0] && n < 5000) begin
      n++; @(negedge clk); rd(3'd5, v);
    end
  endtask

  function automatic logic [63:0] frame(bit w, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, p, r, 2'b10, d};
  endfunction

  function automatic logic [63:0] got();
    logic [63:0] g;
    for (int k = 0; k < 64; k++) g[63 - k] = cap[(base + k) % 2048];
    return g;
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg%0d", a), v, 0);
    end
    chk("R1 mdc/oe", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_addr;
    logic [31:0] v;
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v);
    chk("R2 packing", v, 32'h1F1F);
    wr(3'd2, 32'h0000_0A13); rd(3'd2, v);
    chk("R2 value", v, 32'h0A13);
  endtask

  task automatic t_write;
    int n;
    base = rtot;
    wr(3'd3, 32'h0000_BEEF);
    wait_idle(n);
    chk("R6 busy cycles", n, 256);
    chk("R3 write frame", got(), frame(1, 5'h0A, 5'h13, 16'hBEEF));
  endtask

  task automatic t_read;
    int n, oe_cnt;
    logic [31:0] v;
    phy_val = 16'h5A3C;
    wr(3'd1, 0);
    base = rtot;
    wr(3'd1, 1);
    wait_idle(n);
    chk("R4 read frame", got(), frame(0, 5'h0A, 5'h13, 16'h5A3C));
    oe_cnt = 0;
    for (int k = 0; k < 64; k++) oe_cnt += int'(oecap[(base + k) % 2048]);
    chk("R4 driven bits", oe_cnt, 46);
    rd(3'd4, v);
    chk("R4 read data", v, 32'h5A3C);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    int n;
    wr(3'd1, 1); rd(3'd5, v);
    chk("R5 no start on 1->1", v[0], 0);
    wr(3'd1, 0); rd(3'd5, v);
    chk("R5 no start on clear", v[0], 0);
    phy_val = 16'h0F0F;
    base = rtot;
    wr(3'd1, 1); rd(3'd5, v);
    chk("R5 start on 0->1", v[0], 1);
    wait_idle(n);
    rd(3'd4, v);
    chk("R5 read data", v, 32'h0F0F);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    int n;
    base = rtot;
    wr(3'd3, 32'h1234);
    wr(3'd3, 32'hFFFF);
    wr(3'd2, 32'h0);
    wr(3'd1, 0);
    wr(3'd1, 1);
    rd(3'd3, v); chk("R8 wdata kept", v, 32'h1234);
    rd(3'd2, v); chk("R8 addr kept", v, 32'h0A13);
    wait_idle(n);
    repeat (40) @(negedge clk);
    rd(3'd5, v); chk("R8 no second frame", v[0], 0);
    chk("R8 edge count", rtot - base, 64);
    chk("R8 frame data", got(), frame(1, 5'h0A, 5'h13, 16'h1234));
  endtask

  task automatic t_clk;
    logic [31:0] v;
    int hi, lo, n;
    wr(3'd0, 32'h1C); rd(3'd0, v);
    chk("R7 cfg readback", v, 32'h1C);
    base = rtot;
    wr(3'd3, 32'h00A5);
    while (!mdc) @(negedge clk);
    hi = 0; while (mdc) begin hi++; @(negedge clk); end
    lo = 0; while (!mdc) begin lo++; @(negedge clk); end
    chk("R7 high time", hi, 20);
    chk("R7 low time", lo, 20);
    wait_idle(n);
    chk("R7 frame", got(), frame(1, 5'h0A, 5'h13, 16'h00A5));
    wr(3'd0, 32'h0);
  endtask

  task automatic t_mrst;
    logic [31:0] v;
    int n;
    wr(3'd3, 32'h7777);
    repeat (30) @(negedge clk);
    wr(3'd0, 32'h8000);
    @(negedge clk);
    rd(3'd5, v); chk("R9 busy cleared", v[0], 0);
    chk("R9 mdc/oe low", {mdc, mdio_oe}, 0);
    wr(3'd3, 32'h1111); rd(3'd5, v);
    chk("R9 start ignored", v[0], 0);
    wr(3'd0, 32'h0);
    base = rtot;
    wr(3'd3, 32'h2222); rd(3'd5, v);
    chk("R9 resumes", v[0], 1);
    wait_idle(n);
    chk("R9 frame after release", got(), frame(1, 5'h0A, 5'h13, 16'h2222));
  endtask

  task automatic t_link;
    logic [31:0] v;
    link_fail = 1'b1; rd(3'd5, v);
    chk("R10 link fail set", v, 32'h8);
    link_fail = 1'b0; rd(3'd5, v);
    chk("R10 link fail clear", v, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_addr;
    t_write;
    t_read;
    t_edge;
    t_busy;
    t_clk;
    t_mrst;
    t_link;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule